// File: doc/BRIEF.md
# UART Special-Character Interrupt Unit

This block sits beside a UART receiver and turns six notable receive events into sticky interrupt flags: reception of a multidrop address character, detection of a line break, and matches of the received byte against four programmable flow-control characters (two "resume" characters and two "pause" characters). Each event is gated by its mode enable. The flags live in one byte-wide status register that software reads through a simple read strobe, and reading the register clears it.

A six-bit enable mask selects which flags contribute to a single summary interrupt output. That output feeds one bit of a higher-level interrupt status word. A received character whose ninth bit is 1 counts as an address character and is never compared against the flow-control characters. If an event and a clearing read land in the same cycle, the event wins, so no event is lost.

Top module: `uart_spchar_irq`

## Requirements
- R1: After reset, every flag is 0, `rd_data` reads 0x00 and `irq_summary` is 0.
- R2: Bits 7 and 6 of `rd_data` always read 0.
- R3: A character strobed with `rx_bit9`=1 while `multidrop_en`=1 sets flag bit 5 at the next clock edge; with `multidrop_en`=0 it sets nothing.
- R4: A `brk_pulse` sets flag bit 4 at the next clock edge.
- R5: With `spchar_en`=1, a strobed character with `rx_bit9`=0 equal to `xon1_char`, `xon2_char`, `xoff1_char` or `xoff2_char` sets flag bit 0, 1, 2 or 3 respectively; with `spchar_en`=0, or with `rx_bit9`=1, no such flag is set.
- R6: When one received byte equals more than one comparison character, every matching flag is set in the same edge.
- R7: Flags stay set until a read; during the read cycle `rd_data` shows the flags as they were, and the flags are 0 after the edge unless a new event arrived.
- R8: An event arriving in the same cycle as a read leaves its flag set after that read.
- R9: `irq_summary` equals the OR of flag bits [5:0] ANDed with `irq_mask[5:0]` (mask bit n enables flag bit n), so it falls in the cycle after a clearing read unless a new enabled event arrived.
- R10: A strobed character with `rx_bit9`=0 that matches no comparison character sets no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_valid | input | 1 | One-cycle strobe: a character has been received |
| rx_data | input | 8 | Received byte (low eight data bits) |
| rx_bit9 | input | 1 | Ninth data bit of the received character |
| brk_pulse | input | 1 | One-cycle pulse: line break detected |
| multidrop_en | input | 1 | Enables address-character flagging |
| spchar_en | input | 1 | Enables flow-control character matching |
| xon1_char | input | 8 | First resume comparison character |
| xon2_char | input | 8 | Second resume comparison character |
| xoff1_char | input | 8 | First pause comparison character |
| xoff2_char | input | 8 | Second pause comparison character |
| irq_mask | input | 6 | Per-flag enable for the summary output |
| rd_strobe | input | 1 | Register read; clears the flags at the clock edge |
| rd_data | output | 8 | Flag register contents |
| irq_summary | output | 1 | Masked OR of the flags |

## Verification
Every flag is due exactly one clock edge after its stimulus cycle, and the summary follows the flags combinationally, so both settle in that same cycle. The driver applies each stimulus on a falling edge and queues the expected register and summary values; the monitor takes them two time units after the following rising edge, when one register stage has been crossed. The pre-clear read value is checked in the read cycle itself, before the clearing edge.

// File: rtl/uart_spchar_pkg.sv
package uart_spchar_pkg;
  localparam int unsigned CHAR_W    = 8;
  localparam int unsigned NUM_CMP   = 4;
  localparam int unsigned NUM_FLAGS = 6;
  localparam int unsigned REG_W     = 8;

  // Flag positions (mask bit n enables flag bit n)
  localparam int unsigned FL_XON1  = 0;
  localparam int unsigned FL_XON2  = 1;
  localparam int unsigned FL_XOFF1 = 2;
  localparam int unsigned FL_XOFF2 = 3;
  localparam int unsigned FL_BRK   = 4;
  localparam int unsigned FL_ADDR  = 5;

  typedef logic [NUM_FLAGS-1:0] flag_vec_t;

  // Byte equality used by the comparators
  function automatic logic char_eq(input logic [CHAR_W-1:0] a,
                                   input logic [CHAR_W-1:0] b);
    return ((a ^ b) == '0);
  endfunction

  // Next flag state: read clears, events set; events dominate
  function automatic flag_vec_t flag_next(input flag_vec_t cur,
                                          input logic      clr,
                                          input flag_vec_t set);
    return (clr ? flag_vec_t'('0) : cur) | set;
  endfunction

  // Masked reduction for the summary bit
  function automatic logic masked_any(input flag_vec_t f,
                                      input flag_vec_t m);
    return |(f & m);
  endfunction
endpackage

// File: rtl/spchar_matcher.sv
module spchar_matcher #(
  parameter int unsigned W = 8,
  parameter int unsigned N = 4
) (
  input  logic               enable,
  input  logic [W-1:0]       data,
  input  logic [N-1:0][W-1:0] cmp_chars,
  output logic [N-1:0]       hits
);
  import uart_spchar_pkg::*;

  for (genvar i = 0; i < N; i++) begin : g_cmp
    logic eq;
    always_comb eq = (data == cmp_chars[i]);
    assign hits[i] = enable & eq;
  end
endmodule

// File: rtl/spchar_event_decode.sv
module spchar_event_decode
  import uart_spchar_pkg::*;
#(
  parameter int unsigned W = CHAR_W,
  parameter int unsigned N = NUM_CMP
) (
  input  logic                rx_valid,
  input  logic [W-1:0]        rx_data,
  input  logic                rx_bit9,
  input  logic                brk_pulse,
  input  logic                multidrop_en,
  input  logic                spchar_en,
  input  logic [N-1:0][W-1:0] cmp_chars,
  output logic                addr_evt,
  output logic                data_evt,
  output flag_vec_t           set_vec
);
  logic [N-1:0] char_hits;

  assign addr_evt = rx_valid & rx_bit9;
  assign data_evt = rx_valid & ~rx_bit9;

  spchar_matcher #(.W(W), .N(N)) u_match (
    .enable    (data_evt & spchar_en),
    .data      (rx_data),
    .cmp_chars (cmp_chars),
    .hits      (char_hits)
  );

  always_comb begin
    set_vec          = '0;
    set_vec[N-1:0]   = char_hits;
    set_vec[FL_BRK]  = brk_pulse;
    set_vec[FL_ADDR] = addr_evt & multidrop_en;
  end
endmodule

// File: rtl/spchar_flag_bank.sv
module spchar_flag_bank
  import uart_spchar_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      clr,
  input  flag_vec_t set_vec,
  output flag_vec_t flags
);
  flag_vec_t nxt;
  assign nxt = flag_next(flags, clr, set_vec);

  for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flags[i] <= 1'b0;
      else        flags[i] <= nxt[i];
    end
  end
endmodule

// File: rtl/spchar_summary.sv
module spchar_summary
  import uart_spchar_pkg::*;
(
  input  flag_vec_t flags,
  input  flag_vec_t mask,
  output logic      irq
);
  assign irq = masked_any(flags, mask);
endmodule

// File: rtl/uart_spchar_irq.sv
module uart_spchar_irq
  import uart_spchar_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic [CHAR_W-1:0] rx_data,
  input  logic              rx_bit9,
  input  logic              brk_pulse,
  input  logic              multidrop_en,
  input  logic              spchar_en,
  input  logic [CHAR_W-1:0] xon1_char,
  input  logic [CHAR_W-1:0] xon2_char,
  input  logic [CHAR_W-1:0] xoff1_char,
  input  logic [CHAR_W-1:0] xoff2_char,
  input  logic [NUM_FLAGS-1:0] irq_mask,
  input  logic              rd_strobe,
  output logic [REG_W-1:0]  rd_data,
  output logic              irq_summary
);
  localparam int unsigned PAD_W = REG_W - NUM_FLAGS;

  logic [NUM_CMP-1:0][CHAR_W-1:0] cmp_chars;
  flag_vec_t set_vec;
  flag_vec_t flags;
  logic      addr_evt;
  logic      data_evt;

  always_comb begin
    cmp_chars[FL_XON1]  = xon1_char;
    cmp_chars[FL_XON2]  = xon2_char;
    cmp_chars[FL_XOFF1] = xoff1_char;
    cmp_chars[FL_XOFF2] = xoff2_char;
  end

  spchar_event_decode #(.W(CHAR_W), .N(NUM_CMP)) u_dec (
    .rx_valid     (rx_valid),
    .rx_data      (rx_data),
    .rx_bit9      (rx_bit9),
    .brk_pulse    (brk_pulse),
    .multidrop_en (multidrop_en),
    .spchar_en    (spchar_en),
    .cmp_chars    (cmp_chars),
    .addr_evt     (addr_evt),
    .data_evt     (data_evt),
    .set_vec      (set_vec)
  );

  spchar_flag_bank u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (rd_strobe),
    .set_vec (set_vec),
    .flags   (flags)
  );

  spchar_summary u_sum (
    .flags (flags),
    .mask  (irq_mask),
    .irq   (irq_summary)
  );

  assign rd_data = {{PAD_W{1'b0}}, flags};
endmodule

// File: rtl/uart_spchar_irq_chk.sv
module uart_spchar_irq_chk
  import uart_spchar_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              rx_valid,
  input logic              rx_bit9,
  input logic              brk_pulse,
  input logic              multidrop_en,
  input logic              rd_strobe,
  input logic [NUM_FLAGS-1:0] irq_mask,
  input logic [REG_W-1:0]  rd_data,
  input logic              irq_summary,
  input flag_vec_t         set_vec
);
  // R2
  upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[REG_W-1:NUM_FLAGS] == '0);

  // R3
  addr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_bit9 && multidrop_en) |=> rd_data[FL_ADDR]);

  // R4
  brk_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    brk_pulse |=> rd_data[FL_BRK]);

  // R5
  addr_no_cmp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_bit9) |=> ((rd_data[3:0] & ~$past(rd_data[3:0])) == 4'b0));

  // R7
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_strobe |=> ((rd_data[NUM_FLAGS-1:0] & $past(rd_data[NUM_FLAGS-1:0]))
                    == $past(rd_data[NUM_FLAGS-1:0])));

  // R7
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe && set_vec == '0) |=> rd_data[NUM_FLAGS-1:0] == '0);

  // R8
  read_race_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe && set_vec != '0) |=> ((rd_data[NUM_FLAGS-1:0] & $past(set_vec))
                                      == $past(set_vec)));

  // R9
  summary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_summary == ((rd_data[NUM_FLAGS-1:0] & irq_mask) != '0));
endmodule

bind uart_spchar_irq uart_spchar_irq_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .rx_valid     (rx_valid),
  .rx_bit9      (rx_bit9),
  .brk_pulse    (brk_pulse),
  .multidrop_en (multidrop_en),
  .rd_strobe    (rd_strobe),
  .irq_mask     (irq_mask),
  .rd_data      (rd_data),
  .irq_summary  (irq_summary),
  .set_vec      (set_vec)
);

// File: tb/uart_spchar_irq_tb.sv
module uart_spchar_irq_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_valid = 1'b0, rx_bit9 = 1'b0, brk_pulse = 1'b0, rd_strobe = 1'b0;
  logic [7:0] rx_data = 8'h00;
  logic       multidrop_en = 1'b0, spchar_en = 1'b0;
  logic [7:0] xon1_char = 8'h11, xon2_char = 8'h12, xoff1_char = 8'h13, xoff2_char = 8'h14;
  logic [5:0] irq_mask = 6'h3F;
  logic [7:0] rd_data;
  logic       irq_summary;

  int checks = 0, failures = 0;
  logic [5:0] model = 6'h00;
  bit done = 0;

  typedef struct { logic [7:0] exp_rd; logic exp_irq; string tag; } item_t;
  item_t sb[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_spchar_irq u_dut (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_bit9(rx_bit9), .brk_pulse(brk_pulse), .multidrop_en(multidrop_en),
    .spchar_en(spchar_en), .xon1_char(xon1_char), .xon2_char(xon2_char),
    .xoff1_char(xoff1_char), .xoff2_char(xoff2_char), .irq_mask(irq_mask),
    .rd_strobe(rd_strobe), .rd_data(rd_data), .irq_summary(irq_summary)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Expected events, written as a per-event list from the requirements
  function automatic logic [5:0] events(input logic v, input logic [7:0] d,
                                        input logic b9, input logic brk);
    logic [5:0] e = 6'h00;
    if (brk) e[4] = 1'b1;
    if (v && b9 && multidrop_en) e[5] = 1'b1;
    if (v && !b9 && spchar_en) begin
      if (d == xon1_char)  e[0] = 1'b1;
      if (d == xon2_char)  e[1] = 1'b1;
      if (d == xoff1_char) e[2] = 1'b1;
      if (d == xoff2_char) e[3] = 1'b1;
    end
    return e;
  endfunction

  // Driver: applies one cycle of stimulus and queues the expectation
  task automatic drive(input logic v, input logic [7:0] d, input logic b9,
                       input logic brk, input logic rd, input string tag);
    item_t it;
    logic [5:0] ev;
    @(negedge clk);
    rx_valid = v; rx_data = d; rx_bit9 = b9; brk_pulse = brk; rd_strobe = rd;
    if (rd) check({tag, " R7 pre-clear read"}, rd_data, {2'b00, model});
    ev = events(v, d, b9, brk);
    if (rd) model = 6'h00;
    model = model | ev;
    it.exp_rd = {2'b00, model};
    it.exp_irq = (model & irq_mask) != 6'h00;
    it.tag = tag;
    sb.push_back(it);
    @(posedge clk);
    #3;
    rx_valid = 1'b0; brk_pulse = 1'b0; rd_strobe = 1'b0; rx_bit9 = 1'b0;
  endtask

  // Monitor: one register stage after the stimulus
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (sb.size() != 0) begin
        item_t it;
        it = sb.pop_front();
        check({it.tag, " flags"}, rd_data, it.exp_rd);
        check({it.tag, " R9 summary"}, irq_summary, it.exp_irq);
        check({it.tag, " R2 upper bits"}, rd_data[7:6], 2'b00);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset rd_data", rd_data, 8'h00);
    check("R1 reset summary", irq_summary, 1'b0);
    rst_n = 1'b1;

    drive(0, 8'h00, 0, 0, 0, "R1 idle");
    drive(0, 8'h00, 0, 1, 0, "R4 break");
    drive(0, 8'h00, 0, 0, 0, "R7 sticky");
    drive(0, 8'h00, 0, 0, 1, "R7 read clear");

    drive(1, 8'h55, 1, 0, 0, "R3 addr disabled");
    multidrop_en = 1'b1;
    drive(1, 8'h55, 1, 0, 0, "R3 addr enabled");
    drive(1, 8'h11, 0, 0, 0, "R5 match while disabled");
    spchar_en = 1'b1;
    drive(1, 8'h11, 0, 0, 0, "R5 xon1");
    drive(1, 8'h12, 0, 0, 0, "R5 xon2");
    drive(1, 8'h13, 0, 0, 0, "R5 xoff1");
    drive(0, 8'h00, 0, 0, 1, "R7 read clear 2");
    drive(1, 8'h14, 0, 0, 0, "R5 xoff2");
    drive(1, 8'h13, 1, 0, 0, "R5 bit9 not compared");
    drive(1, 8'h7E, 0, 0, 1, "R10 no match plus read");

    xon2_char = 8'h42; xoff2_char = 8'h42;
    drive(1, 8'h42, 0, 0, 0, "R6 double match");
    drive(0, 8'h00, 0, 1, 1, "R8 break with read");
    drive(1, 8'h11, 0, 0, 1, "R8 xon1 with read");

    irq_mask = 6'h01;
    drive(0, 8'h00, 0, 0, 0, "R9 mask xon1 only");
    drive(0, 8'h00, 0, 0, 1, "R9 clear drops summary");
    irq_mask = 6'h20;
    drive(0, 8'h00, 0, 1, 0, "R9 masked break");
    drive(1, 8'h01, 1, 0, 0, "R9 addr enabled in mask");
    multidrop_en = 1'b0;
    irq_mask = 6'h3F;
    drive(0, 8'h00, 0, 0, 1, "R7 final clear");
    drive(0, 8'h00, 0, 0, 0, "R1 final idle");

    repeat (2) @(posedge clk);
    #4;
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule